// File: doc/BRIEF.md
# Masked Level Interrupt Controller

This block collects thirty level-sensitive interrupt lines from peripherals and presents them to a processor core as one interrupt request wire plus an 8-bit vector bus. Each line is registered into a raw pending vector that follows the line's level. A software-writable mask gates the raw vector into a masked vector. When exactly one masked source is active, the core sees a vector code unique to that source. When several are active together, the core sees one shared code and software must decide which to serve first. No hardware priority encoder is involved.

Two non-maskable lines drive a separate NMI request wire, and one exception line drives a fatal-condition wire. Software reaches the controller through a 32-bit word register port with a five-word window. The mask is the only writable register. The raw vector, the masked vector, the NMI line levels and the exception level are read-only.

Top module: `lvl_irq_ctrl`

## Requirements
- R1: Each raw pending bit equals its interrupt input as sampled at the previous rising clock edge, so setting and clearing both follow the level with one cycle of latency.
- R2: The masked vector is the bitwise AND of the raw vector and the mask register. It changes in the same cycle as either operand.
- R3: The request wire is high exactly when the masked vector is nonzero. When the masked vector is zero, the vector bus reads 0x00.
- R4: With exactly one masked bit i set, the vector bus reads 0x31 + i. Bit 0 gives 0x31 and bit 29 gives 0x4E.
- R5: With two or more masked bits set, the vector bus reads the shared code 0x30.
- R6: The NMI request is high one cycle after either non-maskable input is high, and low one cycle after both are low.
- R7: The fatal request follows the exception input with one cycle of latency. Offset 0x10 bit 0 reads the same level.
- R8: Register map by byte offset: 0x00 is the read/write mask with bits 29:0. 0x04 reads the raw vector, 0x08 the masked vector, 0x0C the two NMI input levels in bits 1:0, and 0x10 the exception level in bit 0. Other bits read zero. Read data and the error flag are registered and appear the cycle after the read strobe. The error flag is low for these offsets.
- R9: A read of any offset at or above 0x14, or of an address with bits 1:0 nonzero, returns zero with the error flag high. A write to any address other than 0x00 leaves the mask unchanged.
- R10: Reset clears the mask, the raw vector and the status registers. While in reset and after it, the request, NMI request and fatal wires are low and the vector bus reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_lines | input | 30 | Level-sensitive interrupt sources |
| nmi_in | input | 2 | Non-maskable interrupt sources |
| guru_in | input | 1 | Unsupported-exception source |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 5 | Byte address within the register window |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| rd_err | output | 1 | Registered flag for a read of an undefined address |
| irq_req | output | 1 | Maskable interrupt request to the core |
| irq_vec | output | 8 | Vector code to the core |
| nmi_req | output | 1 | Non-maskable interrupt request |
| fatal_req | output | 1 | Unsupported-exception report |

## Verification
A raw bit that latches instead of following its line, or a stale mask bit, shows on irq_req and irq_vec one cycle after the input or mask change. The bench compares both wires against its own model of the mask and the registered inputs on every step. A bad popcount or index shows as a wrong vector code at once. The random phase drives sparse masks and lines so that single-source codes come up often alongside the shared code. Register corruption shows on the cycle after a read strobe, and the bench reads the masked vector back on every random step.

// File: rtl/lic_pkg.sv
package lic_pkg;

  typedef enum logic [2:0] {
    SEL_MASK   = 3'd0,
    SEL_RAW    = 3'd1,
    SEL_MASKED = 3'd2,
    SEL_NMI    = 3'd3,
    SEL_GURU   = 3'd4,
    SEL_NONE   = 3'd7
  } reg_sel_e;

  localparam int unsigned NUM_WORDS = 5;

  // Map a word index plus alignment flag to a register select.
  function automatic reg_sel_e word_select(input int unsigned idx, input logic aligned);
    reg_sel_e s;
    if (!aligned || idx >= NUM_WORDS) s = SEL_NONE;
    else begin
      case (idx)
        0: s = SEL_MASK;
        1: s = SEL_RAW;
        2: s = SEL_MASKED;
        3: s = SEL_NMI;
        default: s = SEL_GURU;
      endcase
    end
    return s;
  endfunction

endpackage

// File: rtl/lic_level_sampler.sv
module lic_level_sampler #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  genvar b;
  generate
    for (b = 0; b < W; b++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q[b] <= 1'b0;
        else        q[b] <= d[b];
      end
    end
  endgenerate
endmodule

// File: rtl/lic_vec_encoder.sv
module lic_vec_encoder #(
  parameter int N_SRC = 30,
  parameter int VEC_W = 8,
  parameter logic [VEC_W-1:0] SHARED_CODE = 8'h30,
  parameter logic [VEC_W-1:0] BASE_CODE   = 8'h31
) (
  input  logic [N_SRC-1:0] masked,
  output logic             req,
  output logic             multi,
  output logic [VEC_W-1:0] vec
);
  localparam int CNT_W = $clog2(N_SRC + 1);

  function automatic logic [CNT_W-1:0] pop_count(input logic [N_SRC-1:0] v);
    logic [CNT_W-1:0] c;
    c = '0;
    for (int i = 0; i < N_SRC; i++) c = c + {{(CNT_W-1){1'b0}}, v[i]};
    return c;
  endfunction

  function automatic logic [VEC_W-1:0] low_index(input logic [N_SRC-1:0] v);
    logic [VEC_W-1:0] k;
    k = '0;
    for (int i = N_SRC - 1; i >= 0; i--) if (v[i]) k = VEC_W'(i);
    return k;
  endfunction

  logic [CNT_W-1:0] active_cnt;

  always_comb begin
    active_cnt = pop_count(masked);
    req        = (active_cnt != '0);
    multi      = (active_cnt > CNT_W'(1));
    if (!req)       vec = '0;
    else if (multi) vec = SHARED_CODE;
    else            vec = BASE_CODE + low_index(masked);
  end
endmodule

// File: rtl/lic_reg_port.sv
module lic_reg_port
  import lic_pkg::*;
#(
  parameter int N_SRC  = 30,
  parameter int N_NMI  = 2,
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [N_SRC-1:0]  raw,
  input  logic [N_SRC-1:0]  masked,
  input  logic [N_NMI-1:0]  nmi_lvl,
  input  logic              guru_lvl,
  output logic [N_SRC-1:0]  mask_q,
  output logic [DATA_W-1:0] rdata,
  output logic              rd_err
);
  reg_sel_e          sel;
  logic [DATA_W-1:0] rd_val;

  always_comb begin
    sel    = word_select(int'(addr[ADDR_W-1:2]), addr[1:0] == 2'b00);
    rd_val = '0;
    case (sel)
      SEL_MASK:   rd_val[N_SRC-1:0] = mask_q;
      SEL_RAW:    rd_val[N_SRC-1:0] = raw;
      SEL_MASKED: rd_val[N_SRC-1:0] = masked;
      SEL_NMI:    rd_val[N_NMI-1:0] = nmi_lvl;
      SEL_GURU:   rd_val[0]         = guru_lvl;
      default:    rd_val            = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else if (wr_en && sel == SEL_MASK) mask_q <= wdata[N_SRC-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata  <= '0;
      rd_err <= 1'b0;
    end else if (rd_en) begin
      rdata  <= rd_val;
      rd_err <= (sel == SEL_NONE);
    end
  end
endmodule

// File: rtl/lvl_irq_ctrl.sv
module lvl_irq_ctrl #(
  parameter int N_SRC  = 30,
  parameter int N_NMI  = 2,
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32,
  parameter int VEC_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  irq_lines,
  input  logic [N_NMI-1:0]  nmi_in,
  input  logic              guru_in,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rd_err,
  output logic              irq_req,
  output logic [VEC_W-1:0]  irq_vec,
  output logic              nmi_req,
  output logic              fatal_req
);
  // Internal events brought out as named wires for the checker.
  logic [N_SRC-1:0] raw_q;
  logic [N_SRC-1:0] mask_q;
  logic [N_SRC-1:0] masked_w;
  logic [N_NMI-1:0] nmi_q;
  logic             guru_q;
  logic             multi_w;

  lic_level_sampler #(.W(N_SRC)) u_irq_s (
    .clk(clk), .rst_n(rst_n), .d(irq_lines), .q(raw_q));
  lic_level_sampler #(.W(N_NMI)) u_nmi_s (
    .clk(clk), .rst_n(rst_n), .d(nmi_in), .q(nmi_q));
  lic_level_sampler #(.W(1)) u_guru_s (
    .clk(clk), .rst_n(rst_n), .d(guru_in), .q(guru_q));

  assign masked_w  = raw_q & mask_q;
  assign nmi_req   = |nmi_q;
  assign fatal_req = guru_q;

  lic_vec_encoder #(.N_SRC(N_SRC), .VEC_W(VEC_W)) u_enc (
    .masked(masked_w), .req(irq_req), .multi(multi_w), .vec(irq_vec));

  lic_reg_port #(.N_SRC(N_SRC), .N_NMI(N_NMI), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .raw(raw_q), .masked(masked_w), .nmi_lvl(nmi_q),
    .guru_lvl(guru_q), .mask_q(mask_q), .rdata(rdata), .rd_err(rd_err));
endmodule

// File: rtl/lic_checker.sv
module lic_checker #(
  parameter int N_SRC  = 30,
  parameter int N_NMI  = 2,
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32,
  parameter int VEC_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [N_SRC-1:0]  irq_lines,
  input logic [N_NMI-1:0]  nmi_in,
  input logic              guru_in,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] rdata,
  input logic              rd_err,
  input logic              irq_req,
  input logic [VEC_W-1:0]  irq_vec,
  input logic              nmi_req,
  input logic              fatal_req,
  input logic [N_SRC-1:0]  raw,
  input logic [N_SRC-1:0]  mask,
  input logic [N_SRC-1:0]  masked,
  input logic              multi
);
  logic past_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  assert_raw_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> raw == $past(irq_lines));

  assert_mask_gates_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((masked & ~mask) == '0) && ((masked & ~raw) == '0));

  assert_req_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (masked != '0) == irq_req);

  assert_idle_vec_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_req |-> irq_vec == '0);

  assert_single_vec_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(masked) == 1) |-> (irq_vec >= VEC_W'(8'h31)) && !multi);

  assert_shared_vec_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(masked) > 1) |-> irq_vec == VEC_W'(8'h30));

  assert_nmi_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> nmi_req == (|$past(nmi_in)));

  assert_fatal_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> fatal_req == $past(guru_in));

  assert_ro_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(wr_en) && $past(addr) != '0) |-> mask == $past(mask));

  assert_undef_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_err |-> rdata == '0);
endmodule

bind lvl_irq_ctrl lic_checker #(
  .N_SRC(N_SRC), .N_NMI(N_NMI), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .VEC_W(VEC_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .nmi_in(nmi_in),
  .guru_in(guru_in), .wr_en(wr_en), .addr(addr), .rdata(rdata), .rd_err(rd_err),
  .irq_req(irq_req), .irq_vec(irq_vec), .nmi_req(nmi_req), .fatal_req(fatal_req),
  .raw(raw_q), .mask(mask_q), .masked(masked_w), .multi(multi_w)
);

// File: tb/lvl_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module lvl_irq_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [29:0] irq_lines = '0;
  logic [1:0]  nmi_in = '0;
  logic        guru_in = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rd_err;
  logic        irq_req;
  logic [7:0]  irq_vec;
  logic        nmi_req;
  logic        fatal_req;

  int checks = 0;
  int fails  = 0;
  logic [29:0] mdl_mask = '0;

  always #5 clk = ~clk;

  lvl_irq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .nmi_in(nmi_in),
    .guru_in(guru_in), .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .rd_err(rd_err), .irq_req(irq_req), .irq_vec(irq_vec),
    .nmi_req(nmi_req), .fatal_req(fatal_req));

  function automatic logic [7:0] exp_vec(input logic [29:0] m);
    int n;
    n = $countones(m);
    if (n == 0) return 8'h00;
    if (n > 1)  return 8'h30;
    for (int i = 0; i < 30; i++) if (m[i]) return 8'h31 + 8'(i);
    return 8'hFF;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic reg_write(input logic [4:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    step();
    wr_en = 1'b0;
    if (a == 5'h00) mdl_mask = d[29:0];
  endtask

  task automatic reg_read(input logic [4:0] a, output logic [31:0] d, output logic e);
    rd_en = 1'b1; addr = a;
    step();
    rd_en = 1'b0;
    d = rdata; e = rd_err;
  endtask

  // Drive lines, wait one edge, check request and vector.
  task automatic apply_irq(input logic [29:0] v, input string tag);
    irq_lines = v;
    step();
    chk({tag, " req"}, 32'(irq_req), 32'((v & mdl_mask) != 0));
    chk({tag, " vec"}, 32'(irq_vec), 32'(exp_vec(v & mdl_mask)));
  endtask

  initial begin
    #(200000 * 10);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic        e;
    void'($urandom(32'h1F3A_5C07));
    irq_lines = 30'h0000_0005;
    repeat (3) step();
    // R10: outputs low in reset
    chk("R10 req in reset", 32'(irq_req), 0);
    chk("R10 vec in reset", 32'(irq_vec), 0);
    rst_n = 1'b1;
    step(); step();
    chk("R10 req after reset (mask clear)", 32'(irq_req), 0);
    chk("R10 nmi after reset", 32'(nmi_req), 0);
    chk("R10 fatal after reset", 32'(fatal_req), 0);
    reg_read(5'h00, d, e);
    chk("R10 mask reads zero", d, 0);
    reg_read(5'h04, d, e);
    chk("R1 raw read", d, 32'h5);
    chk("R8 err low", 32'(e), 0);

    // R8: mask read/write
    reg_write(5'h00, 32'hFFFF_FFFF);
    reg_read(5'h00, d, e);
    chk("R8 mask upper bits zero", d, 32'h3FFF_FFFF);
    step();
    chk("R5 two lines shared", 32'(irq_vec), 32'h30);

    apply_irq(30'h0, "R3 idle");
    apply_irq(30'h1, "R4 bit0");
    chk("R4 bit0 code", 32'(irq_vec), 32'h31);
    apply_irq(30'h2000_0000, "R4 bit29");
    chk("R4 bit29 code", 32'(irq_vec), 32'h4E);
    apply_irq(30'h2000_0001, "R5 ends");
    apply_irq(30'h3FFF_FFFF, "R5 all");
    apply_irq(30'h0, "R1 clear follows level");

    // R2: masked-out source
    reg_write(5'h00, 32'h0000_00F0);
    apply_irq(30'h0000_0108, "R2 masked out");
    chk("R2 no req", 32'(irq_req), 0);
    apply_irq(30'h0000_0118, "R2 one through");
    chk("R2 code bit4", 32'(irq_vec), 32'h35);
    reg_read(5'h08, d, e);
    chk("R8 masked read", d, 32'h10);
    // mask change alone changes output
    reg_write(5'h00, 32'h0000_0108);
    chk("R2 mask change vec", 32'(irq_vec), 32'h30);

    // R9: writes elsewhere ignored, undefined reads
    reg_write(5'h04, 32'h0);
    reg_write(5'h10, 32'h0);
    reg_write(5'h02, 32'h0);
    reg_read(5'h00, d, e);
    chk("R9 mask unchanged", d, 32'h108);
    chk("R9 vec unchanged", 32'(irq_vec), 32'h30);
    reg_read(5'h14, d, e);
    chk("R9 0x14 data", d, 0);
    chk("R9 0x14 err", 32'(e), 1);
    reg_read(5'h1C, d, e);
    chk("R9 0x1C err", 32'(e), 1);
    reg_read(5'h06, d, e);
    chk("R9 unaligned data", d, 0);
    chk("R9 unaligned err", 32'(e), 1);
    reg_read(5'h0C, d, e);
    chk("R8 err clears", 32'(e), 0);

    // R6: NMI
    for (int k = 0; k < 4; k++) begin
      nmi_in = 2'(k);
      step();
      chk("R6 nmi req", 32'(nmi_req), 32'(k != 0));
      reg_read(5'h0C, d, e);
      chk("R8 nmi status", d, 32'(k));
    end
    nmi_in = 2'b00;
    step();
    chk("R6 nmi drop", 32'(nmi_req), 0);

    // R7: exception line
    guru_in = 1'b1;
    step();
    chk("R7 fatal high", 32'(fatal_req), 1);
    reg_read(5'h10, d, e);
    chk("R7 status", d, 1);
    guru_in = 1'b0;
    step();
    chk("R7 fatal low", 32'(fatal_req), 0);

    // Random phase
    for (int n = 0; n < 400; n++) begin
      logic [29:0] v;
      if ($urandom_range(0, 3) == 0) begin
        logic [29:0] m;
        m = 30'($urandom);
        if ($urandom_range(0, 1) == 1) m = m & 30'($urandom) & 30'($urandom);
        reg_write(5'h00, {2'b00, m});
      end
      v = 30'($urandom);
      case ($urandom_range(0, 3))
        0: v = 30'h1 << $urandom_range(0, 29);
        1: v = v & 30'($urandom) & 30'($urandom);
        default: ;
      endcase
      apply_irq(v, "R3 R4 R5 random");
      reg_read(5'h08, d, e);
      chk("R2 random masked read", d, {2'b00, v & mdl_mask});
    end

    // R10: reset mid-run
    irq_lines = 30'h0000_0100;
    nmi_in = 2'b01;
    step();
    rst_n = 1'b0;
    #1;
    chk("R10 async req", 32'(irq_req), 0);
    chk("R10 async nmi", 32'(nmi_req), 0);
    step();
    rst_n = 1'b1;
    irq_lines = 30'h0000_0100;
    step(); step();
    chk("R10 mask cleared req", 32'(irq_req), 0);
    mdl_mask = '0;
    reg_read(5'h00, d, e);
    chk("R10 mask cleared read", d, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule